// File: doc/BRIEF.md
# Hotplug Event and General-Purpose Event Register Block

This block collects hotplug notifications for processors and expansion slots and raises a general-purpose event interrupt request toward the system control interrupt combiner. Software sees two register views. A byte view holds a 16-bit event status register, a 16-bit event enable register and a processor presence bitmap of `CPU_MAX` bits. A 32-bit word view holds the slot-inserted mask, the slot-removed mask, an eject register and a read-only removable-slot mask.

Hardware reports events on two sideband ports. A processor event sets or clears one presence bit. A slot event either records a hot insertion or removal, or is flagged as cold configuration, which is ignored. Each recorded event latches a sticky status bit. Software clears status bits one byte at a time by writing ones. A write to the eject register produces a one-cycle strobe that carries the index of the lowest set bit written. Reads are combinational from the address. Writes and events take effect at the next rising clock edge.

Top module: `hp_event_block`

## Requirements
- R1: Byte addresses with bit 5 clear decode `baddr[1:0]`: 0 is status bits 7:0, 1 is status bits 15:8, 2 is enable bits 7:0 and 3 is enable bits 15:8. `brdata` returns the addressed byte.
- R2: A byte write to a status half clears exactly the bits written as one in that half. The other half is left unchanged.
- R3: A byte write to an enable half replaces that half only.
- R4: A processor event (`cpu_evt`) sets status bit 2. A non-cold slot event sets status bit 1. An event that coincides with a clearing write wins.
- R5: A processor event with `cpu_add`=1 sets presence bit `cpu_id`, and with `cpu_add`=0 clears it. Bit `cpu_id` is read as bit `cpu_id%8` of byte address 32+`cpu_id/8`. Byte writes to the presence area have no effect.
- R6: At reset the presence bitmap holds exactly the lowest `BOOT_CPUS` bits set. With the defaults (11), bytes 32, 33 and 34 read 0xFF, 0x07 and 0x00.
- R7: A non-cold slot event first clears both slot masks. It then sets bit `slot_id` in the inserted mask when `slot_add`=1, or in the removed mask when `slot_add`=0.
- R8: A slot event with `slot_cold`=1 changes neither the slot masks nor the status.
- R9: Word address 0 is the inserted mask and word address 1 is the removed mask. Both are fully readable and writable. A same-cycle non-cold slot event takes priority over the write.
- R10: Word address 3 reads as the inverse of `NONREMOVABLE` and ignores writes. Word address 2 (eject) reads as zero.
- R11: A write of a nonzero value to word address 2 pulses `eject_vld` for exactly the following cycle, with `eject_slot` set to the index of the lowest set bit of the value. A write of zero produces no pulse.
- R12: `gpe_irq` is high exactly when status AND enable has bit 1 or bit 2 set.
- R13: After reset, status, enable and both slot masks are zero, and `gpe_irq` and `eject_vld` are low.

Bus inputs are sampled on the rising edge of `clk`. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bwr | input | 1 | Byte write strobe |
| baddr | input | 6 | Byte address: bit 5 selects the presence area |
| bwdata | input | 8 | Byte write data |
| brdata | output | 8 | Byte read data (combinational) |
| wwr | input | 1 | Word write strobe |
| waddr | input | 2 | Word register address |
| wwdata | input | 32 | Word write data |
| wrdata | output | 32 | Word read data (combinational) |
| cpu_evt | input | 1 | Processor hotplug event |
| cpu_add | input | 1 | 1 = add, 0 = remove |
| cpu_id | input | 8 | Processor index |
| slot_evt | input | 1 | Slot hotplug event |
| slot_add | input | 1 | 1 = insertion, 0 = removal |
| slot_cold | input | 1 | Event belongs to cold configuration |
| slot_id | input | 5 | Slot index |
| gpe_irq | output | 1 | Event interrupt request |
| eject_vld | output | 1 | One-cycle eject strobe |
| eject_slot | output | 5 | Slot selected by the eject write |

## Verification
The embedded properties assume that `cpu_id` is below `CPU_MAX` and `slot_id` below the slot count. The cold-event property also assumes that no word write lands in the same cycle as a cold slot event. The stimulus draws identifiers only from the valid ranges and issues every event and bus write in a cycle of its own. Because of this, the same-cycle priority rules are never exercised by the bench and are stated as requirements only. Random register writes, processor events and slot events are checked after each step against a bench model. Directed cases cover the reset contents, the half-preserving clear, cold events, ignored writes and eject values at both ends of the word.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int GPE_SLOT_BIT = 1;
    localparam int GPE_CPU_BIT  = 2;
    localparam logic [15:0] GPE_IRQ_MASK = 16'h0006;

    typedef enum logic [1:0] {
        GB_STS_LO = 2'd0,
        GB_STS_HI = 2'd1,
        GB_EN_LO  = 2'd2,
        GB_EN_HI  = 2'd3
    } gpe_byte_e;

    typedef enum logic [1:0] {
        WA_INS   = 2'd0,
        WA_REM   = 2'd1,
        WA_EJECT = 2'd2,
        WA_RMV   = 2'd3
    } word_reg_e;

    function automatic logic [15:0] evt_set_vec(input logic cpu, input logic slot);
        logic [15:0] v;
        v = '0;
        v[GPE_CPU_BIT]  = cpu;
        v[GPE_SLOT_BIT] = slot;
        return v;
    endfunction

endpackage

// File: rtl/gpe_regs.sv
module gpe_regs
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  gpe_byte_e  sel,
    input  logic [7:0] wdata,
    input  logic       set_cpu,
    input  logic       set_slot,
    output logic [7:0] rdata,
    output logic       irq
);
    logic [15:0] sts, en, sts_nxt, en_nxt, clr;

    always_comb begin
        clr    = '0;
        en_nxt = en;
        if (wr) begin
            case (sel)
                GB_STS_LO: clr[7:0]    = wdata;
                GB_STS_HI: clr[15:8]   = wdata;
                GB_EN_LO:  en_nxt[7:0] = wdata;
                GB_EN_HI:  en_nxt[15:8] = wdata;
                default: ;
            endcase
        end
        sts_nxt = (sts & ~clr) | evt_set_vec(set_cpu, set_slot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= sts_nxt;
            en  <= en_nxt;
        end
    end

    always_comb begin
        case (sel)
            GB_STS_LO: rdata = sts[7:0];
            GB_STS_HI: rdata = sts[15:8];
            GB_EN_LO:  rdata = en[7:0];
            default:   rdata = en[15:8];
        endcase
    end

    assign irq = |(sts & en & GPE_IRQ_MASK);

    // R4
    cpu_evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        set_cpu |=> sts[GPE_CPU_BIT]);

    // R2
    sts_half_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == GB_STS_LO && !set_cpu && !set_slot)
        |=> (sts[15:8] == $past(sts[15:8])) && ((sts[7:0] & $past(wdata)) == 8'h00));

    // R12
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (en[2:1] == 2'b00) |-> !irq);

endmodule

// File: rtl/cpu_presence.sv
module cpu_presence #(
    parameter int CPU_MAX   = 256,
    parameter int BOOT_CPUS = 11,
    localparam int ID_W    = $clog2(CPU_MAX),
    localparam int NBYTES  = CPU_MAX / 8,
    localparam int BYTE_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              add,
    input  logic [ID_W-1:0]   id,
    input  logic [BYTE_W-1:0] byte_idx,
    output logic [7:0]        rdata
);
    logic [CPU_MAX-1:0] map;

    function automatic logic [CPU_MAX-1:0] boot_map();
        logic [CPU_MAX-1:0] m;
        for (int i = 0; i < CPU_MAX; i++) m[i] = (i < BOOT_CPUS);
        return m;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) map <= boot_map();
        else if (evt) map[id] <= add;
    end

    assign rdata = map[8*byte_idx +: 8];

    // R5
    cpu_add_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && add) |=> map[$past(id)]);

    // R5
    cpu_remove_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !add) |=> !map[$past(id)]);

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
    import hp_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter logic [SLOTS-1:0] NONREMOVABLE = '0,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              add,
    input  logic              cold,
    input  logic [SLOT_W-1:0] slot,
    input  logic              wr,
    input  word_reg_e         waddr,
    input  logic [SLOTS-1:0]  wdata,
    output logic [SLOTS-1:0]  rdata,
    output logic              set_sts,
    output logic              ej_vld,
    output logic [SLOT_W-1:0] ej_slot
);
    logic [SLOTS-1:0] ins, rem;
    logic             hot;

    function automatic logic [SLOT_W-1:0] lowest_set(input logic [SLOTS-1:0] v);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) if (v[i]) r = SLOT_W'(i);
        return r;
    endfunction

    assign hot     = evt && !cold;
    assign set_sts = hot;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins     <= '0;
            rem     <= '0;
            ej_vld  <= 1'b0;
            ej_slot <= '0;
        end else begin
            if (hot) begin
                ins <= add  ? (SLOTS'(1) << slot) : '0;
                rem <= !add ? (SLOTS'(1) << slot) : '0;
            end else if (wr && waddr == WA_INS) begin
                ins <= wdata;
            end else if (wr && waddr == WA_REM) begin
                rem <= wdata;
            end
            ej_vld  <= wr && (waddr == WA_EJECT) && (|wdata);
            ej_slot <= lowest_set(wdata);
        end
    end

    always_comb begin
        case (waddr)
            WA_INS:   rdata = ins;
            WA_REM:   rdata = rem;
            WA_EJECT: rdata = '0;
            default:  rdata = ~NONREMOVABLE;
        endcase
    end

    // R7
    hot_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !cold && add) |=> (ins == (SLOTS'(1) << $past(slot))) && (rem == '0));

    // R8
    cold_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && cold && !wr) |=> $stable(ins) && $stable(rem));

    // R11
    eject_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && waddr == WA_EJECT && wdata == '0) |=> !ej_vld);

    // R11
    eject_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ej_vld |-> $past(wr) && ($past(waddr) == WA_EJECT));

endmodule

// File: rtl/hp_event_block.sv
module hp_event_block
    import hp_pkg::*;
#(
    parameter int CPU_MAX   = 256,
    parameter int BOOT_CPUS = 11,
    parameter int SLOTS     = 32,
    parameter logic [SLOTS-1:0] NONREMOVABLE = 32'h0000_0081,
    localparam int ID_W   = $clog2(CPU_MAX),
    localparam int BYTE_W = $clog2(CPU_MAX / 8),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bwr,
    input  logic [BYTE_W:0]   baddr,
    input  logic [7:0]        bwdata,
    output logic [7:0]        brdata,
    input  logic              wwr,
    input  logic [1:0]        waddr,
    input  logic [SLOTS-1:0]  wwdata,
    output logic [SLOTS-1:0]  wrdata,
    input  logic              cpu_evt,
    input  logic              cpu_add,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic              slot_evt,
    input  logic              slot_add,
    input  logic              slot_cold,
    input  logic [SLOT_W-1:0] slot_id,
    output logic              gpe_irq,
    output logic              eject_vld,
    output logic [SLOT_W-1:0] eject_slot
);
    logic       in_presence;
    logic [7:0] gpe_byte, pres_byte;
    logic       slot_set;

    assign in_presence = baddr[BYTE_W];

    slot_tracker #(.SLOTS(SLOTS), .NONREMOVABLE(NONREMOVABLE)) u_slots (
        .clk(clk), .rst(rst),
        .evt(slot_evt), .add(slot_add), .cold(slot_cold), .slot(slot_id),
        .wr(wwr), .waddr(word_reg_e'(waddr)), .wdata(wwdata), .rdata(wrdata),
        .set_sts(slot_set), .ej_vld(eject_vld), .ej_slot(eject_slot)
    );

    gpe_regs u_gpe (
        .clk(clk), .rst(rst),
        .wr(bwr && !in_presence), .sel(gpe_byte_e'(baddr[1:0])), .wdata(bwdata),
        .set_cpu(cpu_evt), .set_slot(slot_set),
        .rdata(gpe_byte), .irq(gpe_irq)
    );

    cpu_presence #(.CPU_MAX(CPU_MAX), .BOOT_CPUS(BOOT_CPUS)) u_cpus (
        .clk(clk), .rst(rst),
        .evt(cpu_evt), .add(cpu_add), .id(cpu_id),
        .byte_idx(baddr[BYTE_W-1:0]), .rdata(pres_byte)
    );

    assign brdata = in_presence ? pres_byte : gpe_byte;

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !gpe_irq && !eject_vld);

endmodule

// File: tb/hp_event_block_test.sv
`timescale 1ns/1ps
module hp_event_block_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bwr = 0;
    logic [5:0]  baddr = 0;
    logic [7:0]  bwdata = 0;
    logic [7:0]  brdata;
    logic        wwr = 0;
    logic [1:0]  waddr = 0;
    logic [31:0] wwdata = 0;
    logic [31:0] wrdata;
    logic        cpu_evt = 0, cpu_add = 0;
    logic [7:0]  cpu_id = 0;
    logic        slot_evt = 0, slot_add = 0, slot_cold = 0;
    logic [4:0]  slot_id = 0;
    logic        gpe_irq, eject_vld;
    logic [4:0]  eject_slot;

    localparam logic [31:0] NONRMV = 32'h0000_0081;

    int checks = 0;
    int fails  = 0;

    logic [15:0]  m_sts, m_en;
    logic [255:0] m_pres;
    logic [31:0]  m_ins, m_rem;

    always #2 clk = ~clk;

    hp_event_block uut (
        .clk(clk), .rst(rst), .bwr(bwr), .baddr(baddr), .bwdata(bwdata), .brdata(brdata),
        .wwr(wwr), .waddr(waddr), .wwdata(wwdata), .wrdata(wrdata),
        .cpu_evt(cpu_evt), .cpu_add(cpu_add), .cpu_id(cpu_id),
        .slot_evt(slot_evt), .slot_add(slot_add), .slot_cold(slot_cold), .slot_id(slot_id),
        .gpe_irq(gpe_irq), .eject_vld(eject_vld), .eject_slot(eject_slot)
    );

    function automatic logic exp_irq();
        return |(m_sts & m_en & 16'h0006);
    endfunction

    function automatic logic [4:0] low_bit(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_byte(input logic [5:0] a, output logic [7:0] d);
        baddr = a;
        #1;
        d = brdata;
    endtask

    task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
        waddr = a;
        #1;
        d = wrdata;
    endtask

    task automatic check_state(input string tag, input int pidx);
        logic [7:0]  b;
        logic [31:0] w;
        rd_byte(6'd0, b); chk({tag, " R1 sts lo"}, b, m_sts[7:0]);
        rd_byte(6'd1, b); chk({tag, " R1 sts hi"}, b, m_sts[15:8]);
        rd_byte(6'd2, b); chk({tag, " R3 en lo"}, b, m_en[7:0]);
        rd_byte(6'd3, b); chk({tag, " R3 en hi"}, b, m_en[15:8]);
        chk({tag, " R12 irq"}, gpe_irq, exp_irq());
        rd_byte(6'(32 + pidx), b); chk({tag, " R5 presence"}, b, m_pres[8*pidx +: 8]);
        rd_word(2'd0, w); chk({tag, " R9 inserted"}, w, m_ins);
        rd_word(2'd1, w); chk({tag, " R9 removed"}, w, m_rem);
        rd_word(2'd2, w); chk({tag, " R10 eject read"}, w, 32'h0);
        rd_word(2'd3, w); chk({tag, " R10 removable"}, w, ~NONRMV);
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); bwr = 1; baddr = a; bwdata = d;
        @(negedge clk); bwr = 0;
        if (!a[5]) begin
            case (a[1:0])
                2'd0: m_sts[7:0]  = m_sts[7:0]  & ~d;
                2'd1: m_sts[15:8] = m_sts[15:8] & ~d;
                2'd2: m_en[7:0]   = d;
                default: m_en[15:8] = d;
            endcase
        end
    endtask

    task automatic wwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wwr = 1; waddr = a; wwdata = d;
        @(negedge clk); wwr = 0;
        if (a == 2'd2) begin
            chk("R11 eject strobe", eject_vld, |d);
            if (|d) chk("R11 eject slot", eject_slot, low_bit(d));
            @(negedge clk);
            chk("R11 strobe one cycle", eject_vld, 1'b0);
        end
        if (a == 2'd0) m_ins = d;
        if (a == 2'd1) m_rem = d;
    endtask

    task automatic cpu_ev(input logic add, input logic [7:0] id);
        @(negedge clk); cpu_evt = 1; cpu_add = add; cpu_id = id;
        @(negedge clk); cpu_evt = 0;
        m_pres[id] = add;
        m_sts[2] = 1'b1;
    endtask

    task automatic slot_ev(input logic add, input logic cold, input logic [4:0] s);
        @(negedge clk); slot_evt = 1; slot_add = add; slot_cold = cold; slot_id = s;
        @(negedge clk); slot_evt = 0;
        if (!cold) begin
            m_ins = '0; m_rem = '0;
            if (add) m_ins[s] = 1'b1; else m_rem[s] = 1'b1;
            m_sts[1] = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20240611));
        m_sts = '0; m_en = '0; m_ins = '0; m_rem = '0;
        for (int i = 0; i < 256; i++) m_pres[i] = (i < 11);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R13 / R6 reset contents
        check_state("reset R13", 0);
        rd_byte(6'd32, b); chk("R6 boot byte0", b, 8'hFF);
        rd_byte(6'd33, b); chk("R6 boot byte1", b, 8'h07);
        rd_byte(6'd34, b); chk("R6 boot byte2", b, 8'h00);
        chk("R13 eject idle", eject_vld, 1'b0);

        // R4 / R12: cpu event raises irq once enabled
        cpu_ev(1'b1, 8'd255);
        check_state("R4 cpu add", 31);
        chk("R12 irq off while disabled", gpe_irq, 1'b0);
        bwrite(6'd2, 8'h04);
        chk("R12 irq on", gpe_irq, 1'b1);
        // R2 clear high half leaves low half
        bwrite(6'd3, 8'hFF);
        bwrite(6'd1, 8'hFF);
        check_state("R2 hi clear", 0);
        bwrite(6'd0, 8'h04);
        check_state("R2 lo clear", 0);
        chk("R12 irq cleared", gpe_irq, 1'b0);

        // R5 remove and ignored presence writes
        cpu_ev(1'b0, 8'd0);
        bwrite(6'd32, 8'hFF);
        bwrite(6'd63, 8'h00);
        check_state("R5 remove+ignored write", 0);
        check_state("R5 top byte", 31);

        // R7 / R8
        slot_ev(1'b1, 1'b0, 5'd31);
        check_state("R7 insert", 0);
        slot_ev(1'b0, 1'b0, 5'd3);
        check_state("R7 remove", 0);
        bwrite(6'd0, 8'h02);
        slot_ev(1'b1, 1'b1, 5'd9);
        check_state("R8 cold", 0);

        // R10 ignored removable write, R11 eject corners
        wwrite(2'd3, 32'h0000_0000);
        check_state("R10 rmv write", 1);
        wwrite(2'd2, 32'h0);
        wwrite(2'd2, 32'h8000_0000);
        wwrite(2'd2, 32'h0000_0006);
        wwrite(2'd2, 32'hFFFF_FFFF);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0: bwrite(6'($urandom_range(0, 3)), 8'($urandom));
                1: bwrite(6'($urandom_range(32, 63)), 8'($urandom));
                2: cpu_ev(1'($urandom), 8'($urandom));
                3: slot_ev(1'($urandom), ($urandom_range(0, 3) == 0), 5'($urandom));
                4: wwrite(2'($urandom_range(0, 1)), $urandom);
                5: wwrite(2'd2, ($urandom_range(0, 3) == 0) ? 32'h0 : (32'h1 << $urandom_range(0, 31)) | ($urandom & $urandom));
                default: wwrite(2'd3, $urandom);
            endcase
            check_state("random", $urandom_range(0, 31));
        end

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule